// File: doc/BRIEF.md
# Power Mode and Clock-Gating Controller

This block sequences the operating modes of a small processor subsystem. It produces the enables for the CPU clock, the bus clock, every peripheral clock and the USB clock. It also drives the PLL-bypass select and the switch for the core power domain. Software chooses a mode and per-peripheral clock enables through a plain register write port. A combinational read port returns those settings and a record of the last wake-up cause. The PLL, the dividers, the clock multiplexers and the analog power switch sit outside the block. Here they are represented only by enable and select pins.

Four modes exist. In normal mode everything is clocked, apart from peripherals that software has switched off. Slow mode runs the CPU from the oscillator with the PLL bypassed. Idle mode stops only the CPU clock, and any interrupt line brings the CPU back. Sleep mode stops every core clock and then removes core power. Only the external interrupt lines or the RTC alarm can end sleep. When the core supply reports good, the controller returns to normal mode. Leaving idle or sleep always lands in normal mode and resets the mode request to normal. The USB clock, fed from its own PLL, has a separate enable that only the sleep sequence overrides.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the controller is in normal mode. The CPU, bus and USB clock enables are 1, every peripheral enable reads 1, pll_bypass is 0 and core_pwr_en is 1. The mode register (address 0) reads 0 and the wake record (address 3) reads 0.
- R2: Register address 0 holds the mode request in bits [1:0]: 0 normal, 1 slow, 2 idle, 3 sleep. A write sampled at clock edge k sets the register at edge k, and the outputs take the new mode after edge k+1.
- R3: In slow mode pll_bypass is 1, while the CPU, bus and peripheral enables behave as in normal mode. In every other mode pll_bypass is 0.
- R4: In idle mode cpu_clk_en is 0, and bus_clk_en and the peripheral enables keep their normal-mode values.
- R5: Address 1 bit i is the software enable of peripheral i and may be written in any mode. periph_clk_en[i] equals that bit whenever the bus clock runs, and is 0 otherwise.
- R6: Address 2 bit 0 enables the USB clock. It is independent of normal, slow and idle, and usb_clk_en is forced to 0 only while the sleep sequence is active.
- R7: On entry to sleep, one cycle has all clock enables 0 with core_pwr_en still 1. core_pwr_en falls one edge later.
- R8: In idle mode, any set bit of irq_req, ext_irq or rtc_alarm sampled at an edge returns the outputs to normal mode after that edge, and the mode register reads 0.
- R9: While powered down, irq_req has no effect. A set ext_irq bit or rtc_alarm sampled at an edge raises core_pwr_en after that edge with clocks still off. Clocks return in normal mode after the first later edge at which pwr_good is 1.
- R10: Address 3 records the last wake. Bits [1:0] hold the cause: 1 means an idle exit; 2 means a sleep exit by an external line, which takes precedence over the alarm; 3 means a sleep exit by the alarm alone. Bits [23:8] hold ext_irq as sampled at that wake edge. The record changes only at a wake edge.
- R11: Writes to address 0 take effect only while the controller is in normal or slow mode. In idle and through the sleep sequence they are ignored, and the mode register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| irq_req | input | 8 | Interrupt requests towards the CPU |
| ext_irq | input | 16 | External interrupt lines |
| rtc_alarm | input | 1 | RTC alarm interrupt |
| pwr_good | input | 1 | Core supply is stable |
| cpu_clk_en | output | 1 | CPU core clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| periph_clk_en | output | 8 | Per-peripheral clock enables |
| usb_clk_en | output | 1 | USB clock enable |
| pll_bypass | output | 1 | Select oscillator instead of PLL for the CPU clock |
| core_pwr_en | output | 1 | Core power-domain switch |

## Verification
Register contents and the peripheral and USB enables follow a write at the same edge that samples it. A mode request reaches the clock and bypass outputs one edge after that, and a wake source reaches them at the edge that samples it. Core power falls one edge after the clocks stop, and clocks return at the edge after pwr_good is seen during power-up. The bench drives inputs just after the rising edge and holds a behavioural model that it advances at each rising edge. It compares every output with the model at the falling edge, when each of these latencies has already elapsed. Directed checks are placed at the cycles counted above, to show that an early change or a late change both fail.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SLOW   = 2'd1,
    MODE_IDLE   = 2'd2,
    MODE_SLEEP  = 2'd3
  } pm_mode_e;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_SLOW = 3'd1,
    ST_IDLE = 3'd2,
    ST_GATE = 3'd3,
    ST_OFF  = 3'd4,
    ST_RAMP = 3'd5
  } pm_state_e;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_IRQ  = 2'd1,
    WK_EXT  = 2'd2,
    WK_RTC  = 2'd3
  } pm_wake_e;

  localparam int unsigned REG_AW = 2;
  localparam logic [REG_AW-1:0] A_MODE = 2'd0;
  localparam logic [REG_AW-1:0] A_PCLK = 2'd1;
  localparam logic [REG_AW-1:0] A_USB  = 2'd2;
  localparam logic [REG_AW-1:0] A_WAKE = 2'd3;

  localparam int unsigned SNAP_LSB = 8;

endpackage

// File: rtl/pm_wake_sense.sv
module pm_wake_sense
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned NUM_EXT = 16
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic               rtc_alarm,
  output logic               any_irq,
  output logic               deep_wake,
  output pm_wake_e           deep_cause
);

  logic ext_any;

  assign ext_any    = |ext_irq;
  assign deep_wake  = ext_any | rtc_alarm;
  assign any_irq    = (|irq_req) | deep_wake;
  assign deep_cause = ext_any ? WK_EXT : (rtc_alarm ? WK_RTC : WK_NONE);

endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pm_mode_e  mode_req,
  input  logic      any_irq,
  input  logic      deep_wake,
  input  pm_wake_e  deep_cause,
  input  logic      pwr_good,
  output pm_state_e state,
  output logic      mode_wr_ok,
  output logic      mode_clr,
  output logic      stat_upd,
  output pm_wake_e  stat_cause
);

  pm_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    mode_clr   = 1'b0;
    stat_upd   = 1'b0;
    stat_cause = WK_NONE;
    unique case (st_q)
      ST_RUN, ST_SLOW: begin
        unique case (mode_req)
          MODE_NORMAL: st_d = ST_RUN;
          MODE_SLOW:   st_d = ST_SLOW;
          MODE_IDLE:   st_d = ST_IDLE;
          MODE_SLEEP:  st_d = ST_GATE;
          default:     st_d = ST_RUN;
        endcase
      end
      ST_IDLE: begin
        if (any_irq) begin
          st_d       = ST_RUN;
          mode_clr   = 1'b1;
          stat_upd   = 1'b1;
          stat_cause = WK_IRQ;
        end
      end
      ST_GATE: st_d = ST_OFF;
      ST_OFF: begin
        if (deep_wake) begin
          st_d       = ST_RAMP;
          stat_upd   = 1'b1;
          stat_cause = deep_cause;
        end
      end
      ST_RAMP: begin
        if (pwr_good) begin
          st_d     = ST_RUN;
          mode_clr = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign state      = st_q;
  assign mode_wr_ok = (st_q == ST_RUN) || (st_q == ST_SLOW);

  AST_OFF_ONLY_FROM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF) |-> ($past(st_q) == ST_GATE || $past(st_q) == ST_OFF)); // R7
  AST_IDLE_EXIT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |=> (st_q == ST_IDLE || st_q == ST_RUN)); // R8
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF && !deep_wake) |=> (st_q == ST_OFF)); // R9
  AST_RAMP_WAITS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RAMP && !pwr_good) |=> (st_q == ST_RAMP)); // R9

endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 8,
  parameter int unsigned NUM_EXT    = 16,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [REG_AW-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  mode_wr_ok,
  input  logic                  mode_clr,
  input  logic                  stat_upd,
  input  pm_wake_e              stat_cause,
  input  logic [NUM_EXT-1:0]    ext_irq,
  output pm_mode_e              mode_req,
  output logic [NUM_PERIPH-1:0] periph_en,
  output logic                  usb_en
);

  localparam int unsigned LOW_USED = (NUM_PERIPH > 2) ? NUM_PERIPH : 2;

  pm_mode_e              mode_q;
  logic [NUM_PERIPH-1:0] pen_q;
  logic                  usb_q;
  pm_wake_e              cause_q;
  logic [NUM_EXT-1:0]    snap_q;
  logic                  wr_mode, wr_pclk, wr_usb;
  logic                  unused_wdata;

  assign wr_mode      = wr_en && (wr_addr == A_MODE) && mode_wr_ok;
  assign wr_pclk      = wr_en && (wr_addr == A_PCLK);
  assign wr_usb       = wr_en && (wr_addr == A_USB);
  assign unused_wdata = ^wr_data[DATA_W-1:LOW_USED];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
    end else if (mode_clr) begin
      mode_q <= MODE_NORMAL;
    end else if (wr_mode) begin
      mode_q <= pm_mode_e'(wr_data[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q <= '1;
      usb_q <= 1'b1;
    end else begin
      if (wr_pclk) pen_q <= wr_data[NUM_PERIPH-1:0];
      if (wr_usb)  usb_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= WK_NONE;
      snap_q  <= '0;
    end else if (stat_upd) begin
      cause_q <= stat_cause;
      snap_q  <= ext_irq;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_MODE: rd_data[1:0] = mode_q;
      A_PCLK: rd_data[NUM_PERIPH-1:0] = pen_q;
      A_USB:  rd_data[0] = usb_q;
      A_WAKE: begin
        rd_data[1:0] = cause_q;
        rd_data[SNAP_LSB +: NUM_EXT] = snap_q;
      end
      default: rd_data = '0;
    endcase
  end

  assign mode_req  = mode_q;
  assign periph_en = pen_q;
  assign usb_en    = usb_q;

  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_wr_ok && !mode_clr) |=> $stable(mode_q)); // R11
  AST_STATUS_ONLY_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_upd |=> ($stable(cause_q) && $stable(snap_q))); // R10

endmodule

// File: rtl/pm_clk_gate.sv
module pm_clk_gate
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  pm_state_e             state,
  input  logic [NUM_PERIPH-1:0] periph_en,
  input  logic                  usb_en,
  output logic                  cpu_clk_en,
  output logic                  bus_clk_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic                  usb_clk_en,
  output logic                  pll_bypass,
  output logic                  core_pwr_en
);

  logic cpu_run, bus_run;

  assign cpu_run     = (state == ST_RUN) || (state == ST_SLOW);
  assign bus_run     = cpu_run || (state == ST_IDLE);
  assign cpu_clk_en  = cpu_run;
  assign bus_clk_en  = bus_run;
  assign usb_clk_en  = usb_en & bus_run;
  assign pll_bypass  = (state == ST_SLOW);
  assign core_pwr_en = (state != ST_OFF);

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_pgate
    assign periph_clk_en[i] = periph_en[i] & bus_run;
  end

  AST_GATE_BEFORE_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_pwr_en) |-> $past(!bus_clk_en && !cpu_clk_en)); // R7
  AST_NO_CLK_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_en |-> (!bus_clk_en && !cpu_clk_en && !usb_clk_en)); // R7
  AST_BYPASS_RUNS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    pll_bypass |-> (cpu_clk_en && bus_clk_en)); // R3
  AST_PERIPH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_clk_en & ~periph_en) == '0); // R5

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 8,
  parameter int unsigned NUM_IRQ    = 8,
  parameter int unsigned NUM_EXT    = 16,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [1:0]            rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NUM_IRQ-1:0]    irq_req,
  input  logic [NUM_EXT-1:0]    ext_irq,
  input  logic                  rtc_alarm,
  input  logic                  pwr_good,
  output logic                  cpu_clk_en,
  output logic                  bus_clk_en,
  output logic [NUM_PERIPH-1:0] periph_clk_en,
  output logic                  usb_clk_en,
  output logic                  pll_bypass,
  output logic                  core_pwr_en
);

  pm_mode_e              mode_req;
  pm_state_e             state;
  pm_wake_e              deep_cause, stat_cause;
  logic                  any_irq, deep_wake;
  logic                  mode_wr_ok, mode_clr, stat_upd;
  logic [NUM_PERIPH-1:0] periph_en;
  logic                  usb_en;

  pm_wake_sense #(.NUM_IRQ(NUM_IRQ), .NUM_EXT(NUM_EXT)) u_sense (
    .irq_req    (irq_req),
    .ext_irq    (ext_irq),
    .rtc_alarm  (rtc_alarm),
    .any_irq    (any_irq),
    .deep_wake  (deep_wake),
    .deep_cause (deep_cause)
  );

  pm_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_req   (mode_req),
    .any_irq    (any_irq),
    .deep_wake  (deep_wake),
    .deep_cause (deep_cause),
    .pwr_good   (pwr_good),
    .state      (state),
    .mode_wr_ok (mode_wr_ok),
    .mode_clr   (mode_clr),
    .stat_upd   (stat_upd),
    .stat_cause (stat_cause)
  );

  pm_regs #(.NUM_PERIPH(NUM_PERIPH), .NUM_EXT(NUM_EXT), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .mode_wr_ok (mode_wr_ok),
    .mode_clr   (mode_clr),
    .stat_upd   (stat_upd),
    .stat_cause (stat_cause),
    .ext_irq    (ext_irq),
    .mode_req   (mode_req),
    .periph_en  (periph_en),
    .usb_en     (usb_en)
  );

  pm_clk_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .periph_en     (periph_en),
    .usb_en        (usb_en),
    .cpu_clk_en    (cpu_clk_en),
    .bus_clk_en    (bus_clk_en),
    .periph_clk_en (periph_clk_en),
    .usb_clk_en    (usb_clk_en),
    .pll_bypass    (pll_bypass),
    .core_pwr_en   (core_pwr_en)
  );

  AST_WAKE_RETURNS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |=> (mode_req == MODE_NORMAL && cpu_clk_en && !pll_bypass)); // R8

endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int NP = 8, NI = 8, NE = 16, DW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, wr_en, rtc_alarm, pwr_good;
  logic [1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic [NI-1:0] irq_req;
  logic [NE-1:0] ext_irq;
  logic cpu_clk_en, bus_clk_en, usb_clk_en, pll_bypass, core_pwr_en;
  logic [NP-1:0] periph_clk_en;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_req(irq_req), .ext_irq(ext_irq),
    .rtc_alarm(rtc_alarm), .pwr_good(pwr_good), .cpu_clk_en(cpu_clk_en),
    .bus_clk_en(bus_clk_en), .periph_clk_en(periph_clk_en), .usb_clk_en(usb_clk_en),
    .pll_bypass(pll_bypass), .core_pwr_en(core_pwr_en)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: 0 normal, 1 slow, 2 idle, 3 clocks off, 4 power off, 5 power up
  int m_st = 0, st_n;
  logic [1:0] m_req = 2'd0, rq_n;
  logic [NP-1:0] m_pen = '1;
  logic m_usb = 1'b1;
  logic [31:0] m_stat = 32'd0, sn;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_req = 2'd0; m_pen = '1; m_usb = 1'b1; m_stat = 32'd0;
    end else begin
      st_n = m_st; rq_n = m_req; sn = m_stat;
      if (wr_en && wr_addr == 2'd1) m_pen = wr_data[NP-1:0];
      if (wr_en && wr_addr == 2'd2) m_usb = wr_data[0];
      if (wr_en && wr_addr == 2'd0 && m_st <= 1) rq_n = wr_data[1:0];
      case (m_st)
        0, 1: st_n = int'(m_req);
        2: if ((|irq_req) || (|ext_irq) || rtc_alarm) begin
             st_n = 0; rq_n = 2'd0; sn = (32'(ext_irq) << 8) | 32'd1;
           end
        3: st_n = 4;
        4: if ((|ext_irq) || rtc_alarm) begin
             st_n = 5; sn = (32'(ext_irq) << 8) | ((|ext_irq) ? 32'd2 : 32'd3);
           end
        5: if (pwr_good) begin st_n = 0; rq_n = 2'd0; end
        default: st_n = 0;
      endcase
      m_st = st_n; m_req = rq_n; m_stat = sn;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic bus_e;
      logic [31:0] rd_e;
      bus_e = (m_st <= 2);
      chk("R2/R4 cpu_clk_en", 32'(cpu_clk_en), 32'(m_st <= 1));
      chk("R4 bus_clk_en", 32'(bus_clk_en), 32'(bus_e));
      chk("R5 periph_clk_en", 32'(periph_clk_en), bus_e ? 32'(m_pen) : 32'd0);
      chk("R6 usb_clk_en", 32'(usb_clk_en), 32'(m_usb & bus_e));
      chk("R3 pll_bypass", 32'(pll_bypass), 32'(m_st == 1));
      chk("R7 core_pwr_en", 32'(core_pwr_en), 32'(m_st != 4));
      case (rd_addr)
        2'd0: rd_e = 32'(m_req);
        2'd1: rd_e = 32'(m_pen);
        2'd2: rd_e = 32'(m_usb);
        default: rd_e = m_stat;
      endcase
      chk("R10 rd_data", rd_data, rd_e);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 2'd1;
    irq_req = '0; ext_irq = '0; rtc_alarm = 1'b0; pwr_good = 1'b1;
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 periph", 32'(periph_clk_en), 32'hFF);
    chk("R1 rd pclk", rd_data, 32'hFF);
    chk("R1 clocks", {29'd0, cpu_clk_en, bus_clk_en, usb_clk_en}, 32'd7);
    chk("R1 power/bypass", {30'd0, core_pwr_en, pll_bypass}, 32'd2);
    step(1);
    rd_addr = 2'd3;
    @(negedge clk);
    chk("R1 wake record", rd_data, 32'd0);

    step(1);
    wr(2'd1, 32'h5A);
    @(negedge clk);
    chk("R5 write", 32'(periph_clk_en), 32'h5A);

    wr(2'd0, 32'd1);
    @(negedge clk);
    chk("R2 not yet slow", 32'(pll_bypass), 32'd0);
    step(1);
    @(negedge clk);
    chk("R3 slow bypass", 32'(pll_bypass), 32'd1);
    chk("R3 slow cpu", 32'(cpu_clk_en), 32'd1);
    step(1);
    wr(2'd2, 32'd0);
    @(negedge clk);
    chk("R6 usb off in slow", 32'(usb_clk_en), 32'd0);
    step(1);
    wr(2'd2, 32'd1);
    wr(2'd0, 32'd0);
    step(1);
    @(negedge clk);
    chk("R2 back to normal", 32'(pll_bypass), 32'd0);

    step(1);
    rd_addr = 2'd0;
    wr(2'd0, 32'd2);
    @(negedge clk);
    chk("R2 cpu still on", 32'(cpu_clk_en), 32'd1);
    step(1);
    @(negedge clk);
    chk("R4 idle cpu", 32'(cpu_clk_en), 32'd0);
    chk("R4 idle periph", 32'(periph_clk_en), 32'h5A);
    step(1);
    wr(2'd0, 32'd1);
    @(negedge clk);
    chk("R11 idle write ignored", rd_data, 32'd2);
    step(2);
    irq_req = 8'h08;
    step(1);
    irq_req = '0;
    @(negedge clk);
    chk("R8 cpu back", 32'(cpu_clk_en), 32'd1);
    chk("R8 mode cleared", rd_data, 32'd0);
    step(1);
    rd_addr = 2'd3;
    @(negedge clk);
    chk("R10 idle cause", rd_data, 32'd1);

    step(1);
    wr(2'd0, 32'd2);
    step(2);
    rtc_alarm = 1'b1;
    step(1);
    rtc_alarm = 1'b0;
    @(negedge clk);
    chk("R8 alarm ends idle", 32'(cpu_clk_en), 32'd1);

    step(1);
    wr(2'd0, 32'd3);
    step(1);
    @(negedge clk);
    chk("R7 gated powered", {29'd0, cpu_clk_en, bus_clk_en, core_pwr_en}, 32'd1);
    step(1);
    @(negedge clk);
    chk("R7 power off", 32'(core_pwr_en), 32'd0);
    step(1);
    irq_req = '1; pwr_good = 1'b0;
    step(2);
    irq_req = '0;
    @(negedge clk);
    chk("R9 irq ignored", 32'(core_pwr_en), 32'd0);
    step(1);
    wr(2'd0, 32'd0);
    ext_irq = 16'h0020;
    step(1);
    ext_irq = '0;
    @(negedge clk);
    chk("R9 power up", {30'd0, core_pwr_en, bus_clk_en}, 32'd2);
    step(3);
    @(negedge clk);
    chk("R9 wait good", 32'(cpu_clk_en), 32'd0);
    step(1);
    rd_addr = 2'd0;
    @(negedge clk);
    chk("R11 sleep write ignored", rd_data, 32'd3);
    step(1);
    pwr_good = 1'b1; rd_addr = 2'd3;
    step(1);
    @(negedge clk);
    chk("R9 clocks back", 32'(cpu_clk_en), 32'd1);
    chk("R10 ext cause", rd_data, 32'h2002);

    step(1);
    wr(2'd0, 32'd3);
    step(2);
    rtc_alarm = 1'b1;
    step(1);
    rtc_alarm = 1'b0;
    step(1);
    @(negedge clk);
    chk("R10 rtc cause", rd_data, 32'd3);

    step(1);
    wr(2'd0, 32'd3);
    step(2);
    ext_irq = 16'h8001; rtc_alarm = 1'b1;
    step(1);
    ext_irq = '0; rtc_alarm = 1'b0;
    step(1);
    @(negedge clk);
    chk("R10 ext over rtc", rd_data, 32'h0080_0102);

    step(1);
    wr(2'd0, 32'd1);
    step(1);
    wr(2'd0, 32'd2);
    step(1);
    @(negedge clk);
    chk("R4 idle from slow", {30'd0, pll_bypass, cpu_clk_en}, 32'd0);
    step(1);
    irq_req = 8'h01;
    step(1);
    irq_req = '0;
    step(1);
    @(negedge clk);
    chk("R8 wake lands normal", {30'd0, pll_bypass, cpu_clk_en}, 32'd1);

    step(4);
    done = 1;
    summary();
    $finish;
  end
endmodule